// File: doc/BRIEF.md
# Display Scan Event Interrupt Controller

This block produces the interrupt events of a display read engine while one frame is scanned out. The engine marks each frame with a start strobe and each finished line with a line strobe. A line counter inside the block compares the running count against a programmed frame height and a programmed target line. From that count the block derives six events: frame started, frame ended, target line reached, frame cut short, FIFO underflow, and configuration taken into use.

Every event sets a sticky bit in a status register. An enable register masks the status bits, and the unmasked bits are ORed into one level-sensitive interrupt line. Software reaches the registers through a single-cycle read/write port. Reads are combinational on the address. Writes to the frame geometry registers are held in shadow copies. They take effect on the next frame start, so that a frame already in flight keeps its timing.

Top module: `sei_top`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: A start strobe while the run bit (offset 0x10, bit 0) is set sets status bit 1.
- R3: While the run bit is clear, start, line and underflow strobes set no status bit.
- R4: Status bit 5 is set when a line strobe brings the line count of the current frame to the active target line. The count is zero after a start strobe. A target of 0 never fires.
- R5: Status bit 2 is set when a line strobe brings the count to the active height. Further line strobes are ignored until the next start strobe.
- R6: A start strobe that arrives while the previous frame has not reached its height sets status bit 3 together with bit 1.
- R7: A high `fifo_underflow` while running sets status bit 4.
- R8: The width (0x14, 12 bits), height (0x18, 20 bits) and target line (0x1C, 20 bits) registers read back as written straight away, but the counter uses them only from the next start strobe. That strobe also sets status bit 0, once per batch of writes.
- R9: A write to the status register (0x04) keeps only the bits that are 1 in the written data, so writing zero clears all bits. A bit set by hardware in the same cycle stays set.
- R10: `irq` is high exactly while some status bit and the same bit of the enable register (0x00) are both 1.
- R11: The run bit reads back at 0x10. Unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| frame_start | input | 1 | One-cycle start-of-frame strobe |
| line_done | input | 1 | One-cycle end-of-line strobe |
| fifo_underflow | input | 1 | Pixel FIFO ran empty this cycle |
| irq | output | 1 | Level interrupt |

## Verification
A wrong line count or frame-active flag shows at the ports one cycle after the line strobe that should have produced the frame-end or target-line bit. It shows either as a missing status bit or as a spurious abnormal-end bit on the following start strobe. A lost shadow-dirty flag shows as a missing register-update bit on the first start strobe after a geometry write. It also shows as events that follow the old height. Any status bit that is lost or cleared wrongly shows up on the next status read and on `irq` in the same cycle.

// File: rtl/sei_pkg.sv
package sei_pkg;
   localparam int NUM_EV = 6;

   typedef enum int {
      EV_REGUPD = 0,
      EV_SOF    = 1,
      EV_EOF    = 2,
      EV_ABN    = 3,
      EV_UDF    = 4,
      EV_TGT    = 5
   } ev_idx_e;

   localparam logic [7:0] OFF_EN     = 8'h00;
   localparam logic [7:0] OFF_PEND   = 8'h04;
   localparam logic [7:0] OFF_CTRL   = 8'h10;
   localparam logic [7:0] OFF_WIDTH  = 8'h14;
   localparam logic [7:0] OFF_HEIGHT = 8'h18;
   localparam logic [7:0] OFF_TARGET = 8'h1C;
endpackage

// File: rtl/sei_cfg_shadow.sv
module sei_cfg_shadow #(
   parameter int W_W = 12,
   parameter int H_W = 20
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr_w,
   input  logic           wr_h,
   input  logic           wr_t,
   input  logic [W_W-1:0] wd_w,
   input  logic [H_W-1:0] wd_h,
   input  logic           apply,
   output logic [W_W-1:0] sh_w,
   output logic [H_W-1:0] sh_h,
   output logic [H_W-1:0] sh_t,
   output logic [H_W-1:0] act_h,
   output logic [H_W-1:0] act_t,
   output logic           dirty
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_w  <= '0;
         sh_h  <= '0;
         sh_t  <= '0;
         act_h <= '0;
         act_t <= '0;
         dirty <= 1'b0;
      end else begin
         if (wr_w) sh_w <= wd_w;
         if (wr_h) sh_h <= wd_h;
         if (wr_t) sh_t <= wd_h;
         if (apply) begin
            act_h <= sh_h;
            act_t <= sh_t;
         end
         if (wr_w || wr_h || wr_t) dirty <= 1'b1;
         else if (apply)           dirty <= 1'b0;
      end
   end
endmodule

// File: rtl/sei_line_tracker.sv
module sei_line_tracker
   import sei_pkg::*;
#(
   parameter int H_W = 20,
   parameter int N_EV = NUM_EV
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic            sof,
   input  logic            line_done,
   input  logic            underflow,
   input  logic            dirty,
   input  logic [H_W-1:0]  act_h,
   input  logic [H_W-1:0]  act_t,
   output logic            sof_go,
   output logic [N_EV-1:0] hw_set,
   output logic            active,
   output logic [H_W-1:0]  line_cnt
);
   logic           line_go;
   logic [H_W-1:0] cnt_nx;
   logic           hit_end;

   assign sof_go  = sof & run;
   assign line_go = line_done & run & active & ~sof;
   assign cnt_nx  = line_cnt + 1'b1;
   assign hit_end = line_go && (cnt_nx == act_h);

   always_comb begin
      hw_set            = '0;
      hw_set[EV_REGUPD] = sof_go & dirty;
      hw_set[EV_SOF]    = sof_go;
      hw_set[EV_ABN]    = sof_go & active;
      hw_set[EV_EOF]    = hit_end;
      hw_set[EV_TGT]    = line_go && (cnt_nx == act_t);
      hw_set[EV_UDF]    = underflow & run;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_cnt <= '0;
         active   <= 1'b0;
      end else if (!run) begin
         active   <= 1'b0;
      end else if (sof_go) begin
         line_cnt <= '0;
         active   <= 1'b1;
      end else if (line_go) begin
         line_cnt <= cnt_nx;
         if (hit_end) active <= 1'b0;
      end
   end
endmodule

// File: rtl/sei_event_status.sv
module sei_event_status #(
   parameter int N_EV    = 6,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic            wr_pend,
   input  logic [N_EV-1:0] wd,
   input  logic [N_EV-1:0] hw_set,
   output logic [N_EV-1:0] en_q,
   output logic [N_EV-1:0] pend_q,
   output logic            irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= '0;
         pend_q <= '0;
      end else begin
         if (wr_en) en_q <= wd;
         pend_q <= (wr_pend ? (pend_q & wd) : pend_q) | hw_set;
      end
   end

   generate
      if (IRQ_REG) begin : g_irq_ff
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq <= 1'b0;
            else        irq <= |(pend_q & en_q);
         end
      end else begin : g_irq_comb
         assign irq = |(pend_q & en_q);
      end
   endgenerate
endmodule

// File: rtl/sei_top.sv
module sei_top
   import sei_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int DATA_W  = 32,
   parameter int W_W     = 12,
   parameter int H_W     = 20,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              frame_start,
   input  logic              line_done,
   input  logic              fifo_underflow,
   output logic              irq
);
   localparam int N_EV = NUM_EV;

   generate
      if (DATA_W < H_W || DATA_W < W_W || DATA_W < N_EV) begin : g_bad_data
         $error("sei_top: DATA_W too narrow for register fields");
      end
      if (ADDR_W < 5) begin : g_bad_addr
         $error("sei_top: ADDR_W cannot reach all offsets");
      end
   endgenerate

   logic              run_q;
   logic              wr_en_s, wr_pend_s, wr_ctrl_s, wr_w_s, wr_h_s, wr_t_s;
   logic [W_W-1:0]    sh_w;
   logic [H_W-1:0]    sh_h, sh_t, act_h, act_t, line_cnt;
   logic              dirty, active, sof_go;
   logic [N_EV-1:0]   hw_set, en_q, pend_q;

   assign wr_en_s   = reg_wr && (reg_addr == ADDR_W'(OFF_EN));
   assign wr_pend_s = reg_wr && (reg_addr == ADDR_W'(OFF_PEND));
   assign wr_ctrl_s = reg_wr && (reg_addr == ADDR_W'(OFF_CTRL));
   assign wr_w_s    = reg_wr && (reg_addr == ADDR_W'(OFF_WIDTH));
   assign wr_h_s    = reg_wr && (reg_addr == ADDR_W'(OFF_HEIGHT));
   assign wr_t_s    = reg_wr && (reg_addr == ADDR_W'(OFF_TARGET));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         run_q <= 1'b0;
      else if (wr_ctrl_s) run_q <= reg_wdata[0];
   end

   sei_cfg_shadow #(.W_W(W_W), .H_W(H_W)) u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_w  (wr_w_s),
      .wr_h  (wr_h_s),
      .wr_t  (wr_t_s),
      .wd_w  (reg_wdata[W_W-1:0]),
      .wd_h  (reg_wdata[H_W-1:0]),
      .apply (sof_go),
      .sh_w  (sh_w),
      .sh_h  (sh_h),
      .sh_t  (sh_t),
      .act_h (act_h),
      .act_t (act_t),
      .dirty (dirty)
   );

   sei_line_tracker #(.H_W(H_W), .N_EV(N_EV)) u_trk (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run_q),
      .sof       (frame_start),
      .line_done (line_done),
      .underflow (fifo_underflow),
      .dirty     (dirty),
      .act_h     (act_h),
      .act_t     (act_t),
      .sof_go    (sof_go),
      .hw_set    (hw_set),
      .active    (active),
      .line_cnt  (line_cnt)
   );

   sei_event_status #(.N_EV(N_EV), .IRQ_REG(IRQ_REG)) u_st (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en_s),
      .wr_pend (wr_pend_s),
      .wd      (reg_wdata[N_EV-1:0]),
      .hw_set  (hw_set),
      .en_q    (en_q),
      .pend_q  (pend_q),
      .irq     (irq)
   );

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         ADDR_W'(OFF_EN):     reg_rdata = DATA_W'(en_q);
         ADDR_W'(OFF_PEND):   reg_rdata = DATA_W'(pend_q);
         ADDR_W'(OFF_CTRL):   reg_rdata = DATA_W'(run_q);
         ADDR_W'(OFF_WIDTH):  reg_rdata = DATA_W'(sh_w);
         ADDR_W'(OFF_HEIGHT): reg_rdata = DATA_W'(sh_h);
         ADDR_W'(OFF_TARGET): reg_rdata = DATA_W'(sh_t);
         default:             reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/sei_chk.sv
module sei_chk
   import sei_pkg::*;
#(
   parameter int H_W  = 20,
   parameter int N_EV = NUM_EV
) (
   input logic            clk,
   input logic            rst_n,
   input logic            run,
   input logic            st_wr,
   input logic [N_EV-1:0] pend,
   input logic [N_EV-1:0] hw_set,
   input logic            active,
   input logic [H_W-1:0]  line_cnt,
   input logic [H_W-1:0]  act_h
);
   // R3
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> (hw_set == '0));

   // R9
   sticky_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !st_wr |=> (($past(pend) & ~pend) == '0));

   // R9
   hw_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_set != '0) |=> ((pend & $past(hw_set)) == $past(hw_set)));

   // R5
   count_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && act_h != '0) |-> (line_cnt < act_h));

   // R6
   abn_with_sof_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hw_set[EV_ABN] |-> hw_set[EV_SOF]);
endmodule

bind sei_top sei_chk #(.H_W(H_W), .N_EV(N_EV)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .run      (run_q),
   .st_wr    (wr_pend_s),
   .pend     (pend_q),
   .hw_set   (hw_set),
   .active   (active),
   .line_cnt (line_cnt),
   .act_h    (act_h)
);

// File: tb/tb_sei_top.sv
module tb_sei_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        frame_start = 1'b0;
   logic        line_done = 1'b0;
   logic        fifo_underflow = 1'b0;
   logic        irq;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   sei_top dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frame_start(frame_start),
      .line_done(line_done), .fifo_underflow(fifo_underflow), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic chk_reg(input string req, input logic [7:0] a, input logic [31:0] exp);
      logic [31:0] v;
      rd(a, v);
      chk(req, v, exp);
   endtask

   task automatic sof_p();
      @(negedge clk); frame_start = 1'b1;
      @(negedge clk); frame_start = 1'b0;
   endtask

   task automatic lines(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); line_done = 1'b1;
         @(negedge clk); line_done = 1'b0;
      end
   endtask

   task automatic udf_p();
      @(negedge clk); fifo_underflow = 1'b1;
      @(negedge clk); fifo_underflow = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 irq", {31'd0, irq}, 0);
      chk_reg("R1 en", 8'h00, 0);
      chk_reg("R1 status", 8'h04, 0);
      chk_reg("R1 ctrl", 8'h10, 0);
      chk_reg("R1 height", 8'h18, 0);
      chk_reg("R1 target", 8'h1C, 0);
   endtask

   task automatic t_disabled();
      sof_p(); lines(2); udf_p();
      chk_reg("R3 status while stopped", 8'h04, 0);
   endtask

   task automatic t_config();
      wr(8'h18, 32'd4);
      wr(8'h1C, 32'd2);
      wr(8'h14, 32'hFFFF);
      chk_reg("R8 height readback", 8'h18, 32'd4);
      chk_reg("R8 width 12-bit", 8'h14, 32'hFFF);
      wr(8'h10, 32'd1);
      chk_reg("R11 run readback", 8'h10, 32'd1);
      chk_reg("R11 unmapped", 8'h08, 0);
   endtask

   task automatic t_frame();
      sof_p();
      chk_reg("R2 R8 sof+update", 8'h04, 32'h03);
      wr(8'h04, 0);
      lines(1);
      chk_reg("R4 before target", 8'h04, 0);
      lines(1);
      chk_reg("R4 target hit", 8'h04, 32'h20);
      lines(1);
      chk_reg("R5 before end", 8'h04, 32'h20);
      lines(1);
      chk_reg("R5 frame end", 8'h04, 32'h24);
      wr(8'h04, 0);
      lines(3);
      chk_reg("R5 lines ignored after end", 8'h04, 0);
   endtask

   task automatic t_abnormal();
      sof_p();
      chk_reg("R8 no repeat update", 8'h04, 32'h02);
      wr(8'h04, 0);
      lines(1);
      sof_p();
      chk_reg("R6 short frame", 8'h04, 32'h0A);
      wr(8'h04, 0);
   endtask

   task automatic t_underflow_clear();
      udf_p();
      chk_reg("R7 underflow", 8'h04, 32'h10);
      wr(8'h04, 32'h10);
      chk_reg("R9 write-one keeps", 8'h04, 32'h10);
      wr(8'h04, 0);
      chk_reg("R9 write-zero clears", 8'h04, 0);
   endtask

   task automatic t_shadow();
      wr(8'h18, 32'd2);
      chk_reg("R8 new height visible", 8'h18, 32'd2);
      lines(2);
      chk_reg("R8 old height still used", 8'h04, 32'h20);
      lines(2);
      chk_reg("R8 old height end", 8'h04, 32'h24);
      wr(8'h04, 0);
      sof_p();
      chk_reg("R8 update on sof", 8'h04, 32'h03);
      lines(2);
      chk_reg("R8 new height end", 8'h04, 32'h27);
      wr(8'h04, 0);
   endtask

   task automatic t_irq();
      udf_p();
      chk("R10 masked", {31'd0, irq}, 0);
      wr(8'h00, 32'h04);
      chk("R10 other bit enabled", {31'd0, irq}, 0);
      chk_reg("R10 enable readback", 8'h00, 32'h04);
      wr(8'h00, 32'h10);
      chk("R10 asserted", {31'd0, irq}, 1);
      wr(8'h04, 0);
      chk("R10 deasserted", {31'd0, irq}, 0);
   endtask

   task automatic t_priority();
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 8'h04; reg_wdata = 0; fifo_underflow = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0; fifo_underflow = 1'b0;
      chk_reg("R9 hardware wins", 8'h04, 32'h10);
      wr(8'h04, 0);
   endtask

   task automatic t_target0();
      wr(8'h1C, 0);
      sof_p();
      chk_reg("R8 update for target", 8'h04, 32'h03);
      wr(8'h04, 0);
      lines(2);
      chk_reg("R4 target zero silent", 8'h04, 32'h04);
      wr(8'h04, 0);
   endtask

   task automatic t_stop_midframe();
      sof_p();
      wr(8'h04, 0);
      wr(8'h10, 0);
      lines(2); udf_p(); sof_p();
      chk_reg("R3 stopped mid frame", 8'h04, 0);
   endtask

   initial begin
      fork
         begin
            #20 rst_n = 1'b1;
            @(negedge clk);
            t_reset();
            t_disabled();
            t_config();
            t_frame();
            t_abnormal();
            t_underflow_clear();
            t_shadow();
            t_irq();
            t_priority();
            t_target0();
            t_stop_midframe();
         end
         begin
            repeat (20000) @(posedge clk);
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      disable fork;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule